// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block sits between a memory controller and its data pad logic. On the transmit side it takes a write word made of several bytes, counts the ones in each byte, and sends any byte that holds more than four ones in complemented form. A per-byte flag goes high for each byte that was complemented. The bus therefore carries mostly zeros, and a low-driven terminated lane draws no termination current.

On the receive side the same flag marks each byte that must be complemented back. The encoder is registered and adds one cycle of latency. Its valid travels with the data. The decoder is purely combinational. Each direction has its own enable, so inversion can be switched off for writes and reads separately.

Top module: `dbi_codec`

## Requirements
- R1: While `rst_ni` is low, `tx_valid_o`, `tx_data_o` and `tx_flag_o` are all zero.
- R2: With `wr_dbi_en_i` high, a valid byte holding five or more ones appears on `tx_data_o` bitwise complemented, with its `tx_flag_o` bit high (bit b covers data bits 8b+7..8b).
- R3: With `wr_dbi_en_i` high, a valid byte holding four or fewer ones, exactly four included, appears unchanged, with its flag bit low.
- R4: The decision for each byte depends only on that byte's own bits, never on its neighbours.
- R5: `tx_valid_o` equals `wr_valid_i` delayed by one clock. Encoded data and flags appear in the cycle after the valid input is sampled.
- R6: In a cycle where `wr_valid_i` is low, `tx_data_o` and `tx_flag_o` keep their previous values.
- R7: With `wr_dbi_en_i` low, valid data passes through unchanged and every flag bit is low.
- R8: With `rd_dbi_en_i` high, each byte of `rd_data_o` is the matching byte of `rx_data_i` complemented when its `rx_flag_i` bit is high, and unchanged when that bit is low.
- R9: With `rd_dbi_en_i` low, `rx_flag_i` has no effect and `rd_data_o` equals `rx_data_i`.
- R10: With `wr_dbi_en_i` high, no encoded byte carries more than four ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_dbi_en_i | input | 1 | Enables inversion on the write path |
| rd_dbi_en_i | input | 1 | Enables restoration on the read path |
| wr_valid_i | input | 1 | Write word valid |
| wr_data_i | input | 8*NUM_BYTES | Write word from the controller |
| tx_valid_o | output | 1 | Encoded word valid |
| tx_data_o | output | 8*NUM_BYTES | Encoded word toward the bus |
| tx_flag_o | output | NUM_BYTES | Per-byte inversion flag toward the bus |
| rx_data_i | input | 8*NUM_BYTES | Received word from the bus |
| rx_flag_i | input | NUM_BYTES | Per-byte inversion flag from the bus |
| rd_data_o | output | 8*NUM_BYTES | Restored read word |

## Verification
The bench builds the block with its default of two byte lanes, which makes the write word 16 bits wide. At that width every one of the 65536 write words can be streamed through the encoder, one per clock. This covers every ones-count in each lane, including the exactly-four boundary, and every pairing of an inverted lane with a plain one. The decoder is swept over all 256 byte values against every flag pattern with the read enable both high and low. Extra phases cover pass-through with the write enable low and data holding during idle cycles.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_ONES = 4;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  function automatic logic [CNT_W-1:0] ones_in_byte(input logic [BYTE_W-1:0] b);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + CNT_W'(b[i]);
    return n;
  endfunction
endpackage

// File: rtl/dbi_byte_enc.sv
module dbi_byte_enc
  import dbi_pkg::*;
#(
  parameter int LIMIT = MAX_ONES
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              en_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              inv_o
);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones   = ones_in_byte(byte_i);
    inv_o  = en_i && (ones > CNT_W'(LIMIT));
    byte_o = byte_i ^ {BYTE_W{inv_o}};
  end
endmodule

// File: rtl/dbi_byte_dec.sv
module dbi_byte_dec
  import dbi_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              flag_i,
  input  logic              en_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic inv;

  always_comb begin
    inv    = en_i & flag_i;
    byte_o = byte_i ^ {BYTE_W{inv}};
  end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_dbi_en_i,
  input  logic                 rd_dbi_en_i,
  input  logic                 wr_valid_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic                 tx_valid_o,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic [NUM_BYTES-1:0] tx_flag_o,
  input  logic [DATA_W-1:0]    rx_data_i,
  input  logic [NUM_BYTES-1:0] rx_flag_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic [DATA_W-1:0]    enc_data;
  logic [NUM_BYTES-1:0] enc_flag;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    dbi_byte_enc i_enc (
      .byte_i (wr_data_i[b*BYTE_W +: BYTE_W]),
      .en_i   (wr_dbi_en_i),
      .byte_o (enc_data[b*BYTE_W +: BYTE_W]),
      .inv_o  (enc_flag[b])
    );
    dbi_byte_dec i_dec (
      .byte_i (rx_data_i[b*BYTE_W +: BYTE_W]),
      .flag_i (rx_flag_i[b]),
      .en_i   (rd_dbi_en_i),
      .byte_o (rd_data_o[b*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_flag_o  <= '0;
    end else begin
      tx_valid_o <= wr_valid_i;
      if (wr_valid_i) begin
        tx_data_o <= enc_data;
        tx_flag_o <= enc_flag;
      end
    end
  end
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk
  import dbi_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_dbi_en_i,
  input logic                 rd_dbi_en_i,
  input logic                 wr_valid_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic                 tx_valid_o,
  input logic [DATA_W-1:0]    tx_data_o,
  input logic [NUM_BYTES-1:0] tx_flag_o,
  input logic [DATA_W-1:0]    rx_data_i,
  input logic [NUM_BYTES-1:0] rx_flag_i,
  input logic [DATA_W-1:0]    rd_data_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_IDLE: assert (!tx_valid_o && tx_data_o == '0 && tx_flag_o == '0) else $error("reset state"); // R1
    end
  end

  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> tx_valid_o) else $error("valid lost"); // R5
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !tx_valid_o) else $error("spurious valid"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(tx_data_o) && $stable(tx_flag_o)) else $error("idle change"); // R6
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !wr_dbi_en_i |=> tx_flag_o == '0 && tx_data_o == $past(wr_data_i)) else $error("bypass"); // R7

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane_chk
    AST_HEAVY_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_i && wr_dbi_en_i && ($countones(wr_data_i[b*BYTE_W +: BYTE_W]) > MAX_ONES)
      |=> tx_flag_o[b] && tx_data_o[b*BYTE_W +: BYTE_W] == ~$past(wr_data_i[b*BYTE_W +: BYTE_W]))
      else $error("heavy byte"); // R2
    AST_LIGHT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_i && wr_dbi_en_i && ($countones(wr_data_i[b*BYTE_W +: BYTE_W]) <= MAX_ONES)
      |=> !tx_flag_o[b] && tx_data_o[b*BYTE_W +: BYTE_W] == $past(wr_data_i[b*BYTE_W +: BYTE_W]))
      else $error("light byte"); // R3
    AST_ONES_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_i && wr_dbi_en_i |=> $countones(tx_data_o[b*BYTE_W +: BYTE_W]) <= MAX_ONES)
      else $error("ones cap"); // R10
  end

  always_comb begin
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (rd_dbi_en_i && rx_flag_i[b]) begin
        AST_DEC_RESTORE: assert (rd_data_o[b*BYTE_W +: BYTE_W] == ~rx_data_i[b*BYTE_W +: BYTE_W]) else $error("restore"); // R8
      end else begin
        AST_DEC_PASS: assert (rd_data_o[b*BYTE_W +: BYTE_W] == rx_data_i[b*BYTE_W +: BYTE_W]) else $error("pass"); // R9
      end
    end
  end
endmodule

bind dbi_codec dbi_codec_chk #(.NUM_BYTES(NUM_BYTES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_dbi_en_i(wr_dbi_en_i), .rd_dbi_en_i(rd_dbi_en_i),
  .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .tx_valid_o(tx_valid_o),
  .tx_data_o(tx_data_o), .tx_flag_o(tx_flag_o), .rx_data_i(rx_data_i),
  .rx_flag_i(rx_flag_i), .rd_data_o(rd_data_o)
);

// File: tb/test_dbi_codec.sv
module test_dbi_codec;
  localparam int NB = 2;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0, rx_data = '0;
  logic [NB-1:0] rx_flag = '0;
  logic          tx_valid;
  logic [DW-1:0] tx_data, rd_data;
  logic [NB-1:0] tx_flag;

  int total = 0, bad = 0;
  bit done = 0;

  logic          m_valid = 1'b0;
  logic [DW-1:0] m_data = '0;
  logic [NB-1:0] m_flag = '0;
  logic          m_capped = 1'b0;
  string         cur_tag = "R1";

  always #4 clk = ~clk;

  dbi_codec #(.NUM_BYTES(NB)) i_dbi_codec (
    .clk_i(clk), .rst_ni(rst_n), .wr_dbi_en_i(wr_en), .rd_dbi_en_i(rd_en),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_flag_o(tx_flag), .rx_data_i(rx_data),
    .rx_flag_i(rx_flag), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int ones8(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(b[i]);
    return n;
  endfunction

  task automatic check_out();
    chk(tx_valid === m_valid, "R5", 32'(tx_valid), 32'(m_valid));
    chk({tx_flag, tx_data} === {m_flag, m_data}, cur_tag, 32'({tx_flag, tx_data}), 32'({m_flag, m_data}));
    if (m_capped)
      for (int b = 0; b < NB; b++)
        chk(ones8(tx_data[b*8 +: 8]) <= 4, "R10", 32'(ones8(tx_data[b*8 +: 8])), 32'd4);
  endtask

  // check previous result, drive next word, update model at the edge
  task automatic step(input logic v, input logic [DW-1:0] d, input logic en);
    logic [DW-1:0] q;
    logic [NB-1:0] f;
    @(negedge clk);
    check_out();
    wr_valid = v; wr_data = d; wr_en = en;
    for (int b = 0; b < NB; b++) begin
      f[b] = en && (ones8(d[b*8 +: 8]) > 4);
      q[b*8 +: 8] = f[b] ? ~d[b*8 +: 8] : d[b*8 +: 8];
    end
    @(posedge clk);
    m_valid = v;
    if (v) begin
      m_data = q; m_flag = f; m_capped = en;
      if (!en) cur_tag = "R7";
      else if (f != '0 && f != '1) cur_tag = "R4";
      else if (f != '0) cur_tag = "R2";
      else cur_tag = "R3";
    end else begin
      m_capped = 1'b0;
      cur_tag = "R6";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wr_valid = 1'b1; wr_data = '1; wr_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_valid && tx_data == '0 && tx_flag == '0, "R1", 32'({tx_valid, tx_flag, tx_data}), 32'd0);
    wr_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R10: every 16-bit word, inversion on
    for (int v = 0; v < 65536; v++) step(1'b1, DW'(v), 1'b1);
    // R7: inversion off
    for (int v = 0; v < 256; v++) step(1'b1, {~8'(v), 8'(v)}, 1'b0);
    // R6: idle cycles with changing data and enable
    step(1'b1, 16'hff0f, 1'b1);
    step(1'b0, 16'h0000, 1'b1);
    step(1'b0, 16'h1234, 1'b0);
    step(1'b0, 16'hffff, 1'b1);
    step(1'b1, 16'h0f1f, 1'b1);
    step(1'b0, 16'haaaa, 1'b0);
    step(1'b0, 16'h0000, 1'b0);

    // R8 R9: decoder sweep
    for (int en = 0; en < 2; en++)
      for (int fl = 0; fl < 4; fl++)
        for (int v = 0; v < 256; v++) begin
          logic [DW-1:0] exp;
          rd_en = 1'(en); rx_flag = NB'(fl); rx_data = {8'(v) ^ 8'h5a, 8'(v)};
          #1;
          for (int b = 0; b < NB; b++)
            exp[b*8 +: 8] = (en == 1 && rx_flag[b]) ? ~rx_data[b*8 +: 8] : rx_data[b*8 +: 8];
          chk(rd_data === exp, (en == 1) ? "R8" : "R9", 32'(rd_data), 32'(exp));
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule